// File: doc/BRIEF.md
# Two-Level Error Status Logger with Header Capture

This block keeps the error status of one error group on a packet-based I/O link. Error detectors elsewhere pulse up to 32 event lines for one cycle each. Each event passes through a per-bit log-enable gate. The first logged occurrence of an error raises that error's primary flag. Any later occurrence, while the primary flag is still set, raises the matching secondary flag. Some bit positions are configured as primary-only, and those never raise a secondary flag.

The first primary flag raised by a header-logging error freezes two 128-bit snapshots. One is the received packet header and the other is the related transmitted request header. A format bit inside each header tells a four-doubleword header from a three-doubleword header. For the three-doubleword form the unused low word is stored as zero.

Software reaches the block through a small register port and clears flags by writing ones. A summary interrupt line goes high whenever any set flag has its interrupt enable set.

Top module: `err_log_unit`

## Requirements
- R1: After reset, every readable register reads zero and `irq_o` is low.
- R2: An event on line i is recorded only when bit i of the log-enable register (address 1, bits [31:0]) is set. The same enable bit gates both the primary and the secondary flag of error i.
- R3: A logged event on line i sets status bit i (primary) when that bit is clear. When bit i is already set, the event sets status bit 32+i (secondary) instead. The status register is at address 0.
- R4: Positions named in `PRIM_ONLY_MASK` (bit 11 by default) set their primary flag but never their secondary flag.
- R5: `irq_o` is high exactly when the 64-bit status ANDed with the 64-bit interrupt-enable register (address 2) is nonzero.
- R6: Writing to address 0 clears each status bit whose write-data bit is one. Writes to the header addresses 3 to 6 have no effect.
- R7: When a clearing write and a new logged event hit the same primary bit in the same cycle, the bit ends up set.
- R8: The headers are loaded only when an event sets a primary flag in `HDR_LOG_MASK` (bits 15:0 by default) while no primary flag of that mask is already set. Otherwise they hold their value.
- R9: A header whose format bit (bit 125) is one is stored whole. When that bit is zero, stored bits [31:0] are zero.
- R10: The transmitted request header is captured in the same cycle as the received header. It is read at address 5 (bits 127:64) and address 6 (bits 63:0). The received header is read at address 3 (127:64) and address 4 (63:0).
- R11: Several logged events in one cycle set all of their flags in parallel.
- R12: Address 1 reads zero in bits [63:32], and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 32 | One-cycle error event pulses |
| rx_hdr | input | 128 | Header of the received packet tied to the current event |
| tx_hdr | input | 128 | Header of the related transmitted request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from address) |
| irq_o | output | 1 | Summary interrupt to the top-level error register |

## Verification
A software write-one-to-clear on the status register can land in the same cycle as a new logged event on the same bit. The bench provokes this by first setting a primary flag, then driving a clear of that bit together with a fresh pulse on its event line. The result is judged by reading the status afterwards: the primary flag must be set and the secondary flag must stay clear. A simultaneous burst on several lines is also driven, including a mix of first and repeat occurrences. Its outcome is checked against the bench's own model of the flag and capture rules.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

  localparam int HDR_BITS  = 128;
  localparam int WORD_BITS = 64;
  localparam int ADDR_BITS = 3;
  localparam int HALF_BITS = WORD_BITS / 2;
  localparam int LOW_WORD  = 32;

  typedef enum logic [ADDR_BITS-1:0] {
    RA_STATUS = 3'd0,
    RA_LOG_EN = 3'd1,
    RA_IRQ_EN = 3'd2,
    RA_RX_HI  = 3'd3,
    RA_RX_LO  = 3'd4,
    RA_TX_HI  = 3'd5,
    RA_TX_LO  = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  function automatic logic [HDR_BITS-1:0] trim_hdr(input logic [HDR_BITS-1:0] h,
                                                   input int unsigned fmt_pos);
    logic [HDR_BITS-1:0] r;
    r = h;
    if (!h[fmt_pos]) r[LOW_WORD-1:0] = '0;
    return r;
  endfunction

endpackage

// File: rtl/err_status_core.sv
module err_status_core #(
  parameter int               N_ERR          = 32,
  parameter logic [N_ERR-1:0] PRIM_ONLY_MASK = 32'h0000_0800,
  parameter logic [N_ERR-1:0] HDR_LOG_MASK   = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] evt,
  input  logic [N_ERR-1:0] log_en,
  input  logic [N_ERR-1:0] clr_prim,
  input  logic [N_ERR-1:0] clr_sec,
  output logic [N_ERR-1:0] prim_q,
  output logic [N_ERR-1:0] sec_q,
  output logic             cap_fire
);

  logic [N_ERR-1:0] ev_en;
  logic [N_ERR-1:0] eff_prim;
  logic [N_ERR-1:0] prim_set;
  logic [N_ERR-1:0] sec_set;
  logic [N_ERR-1:0] prim_d;
  logic [N_ERR-1:0] sec_d;
  logic             upd_en;

  always_comb begin
    ev_en    = evt & log_en;
    eff_prim = prim_q & ~clr_prim;
    prim_set = ev_en & ~eff_prim;
    sec_set  = ev_en & eff_prim & ~PRIM_ONLY_MASK;
    prim_d   = eff_prim | prim_set;
    sec_d    = (sec_q & ~clr_sec) | sec_set;
    cap_fire = (|(prim_set & HDR_LOG_MASK)) && !(|(eff_prim & HDR_LOG_MASK));
    upd_en   = (|ev_en) || (|clr_prim) || (|clr_sec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= '0;
      sec_q  <= '0;
    end else if (upd_en) begin
      prim_q <= prim_d;
      sec_q  <= sec_d;
    end
  end

  // R2: no flag rises without a logged event the cycle before
  a_r2_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((({sec_q, prim_q} & ~{$past(sec_q), $past(prim_q)})
               & ~{$past(ev_en), $past(ev_en)}) == '0));

  // R3: a secondary flag only rises where the primary was already set
  a_r3_sec_after_prim: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sec_q & ~$past(sec_q) & ~$past(prim_q)) == '0));

  // R4: primary-only positions never hold a secondary flag
  a_r4_prim_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((sec_q & PRIM_ONLY_MASK) == '0));

  // R7: an event beats a simultaneous clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_en & clr_prim) & ~prim_q) == '0));

endmodule

// File: rtl/err_hdr_capture.sv
module err_hdr_capture
  import err_log_pkg::*;
#(
  parameter int unsigned FMT_POS = 125
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [HDR_BITS-1:0] hdr_in,
  output logic [HDR_BITS-1:0] hdr_q
);

  logic [HDR_BITS-1:0] hdr_d;

  always_comb begin
    hdr_d = trim_hdr(hdr_in, FMT_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hdr_q <= '0;
    else if (load) hdr_q <= hdr_d;
  end

  // R8: header holds unless a capture fires
  a_r8_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hdr_q));

  // R9: a short-format header leaves the low word zero
  a_r9_short_trim: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hdr_in[FMT_POS]) |=> (hdr_q[LOW_WORD-1:0] == '0));

endmodule

// File: rtl/err_reg_if.sv
module err_reg_if
  import err_log_pkg::*;
#(
  parameter int N_ERR = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [N_ERR-1:0]     prim,
  input  logic [N_ERR-1:0]     sec,
  input  logic [HDR_BITS-1:0]  rx_hdr_q,
  input  logic [HDR_BITS-1:0]  tx_hdr_q,
  output logic [N_ERR-1:0]     log_en,
  output logic [N_ERR-1:0]     clr_prim,
  output logic [N_ERR-1:0]     clr_sec,
  output logic [WORD_BITS-1:0] rdata,
  output logic                 irq
);

  logic [N_ERR-1:0]     log_en_q;
  logic [N_ERR-1:0]     log_en_d;
  logic                 log_en_we;
  logic [WORD_BITS-1:0] irq_en_q;
  logic [WORD_BITS-1:0] irq_en_d;
  logic                 irq_en_we;
  logic [WORD_BITS-1:0] status_word;
  logic [WORD_BITS-1:0] log_word;
  reg_addr_e            sel;

  always_comb begin
    sel       = reg_addr_e'(addr);
    log_en_we = wr_en && (sel == RA_LOG_EN);
    irq_en_we = wr_en && (sel == RA_IRQ_EN);
    log_en_d  = wdata[N_ERR-1:0];
    irq_en_d  = wdata;
    if (wr_en && (sel == RA_STATUS)) begin
      clr_prim = wdata[N_ERR-1:0];
      clr_sec  = wdata[HALF_BITS +: N_ERR];
    end else begin
      clr_prim = '0;
      clr_sec  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         log_en_q <= '0;
    else if (log_en_we) log_en_q <= log_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_en_q <= '0;
    else if (irq_en_we) irq_en_q <= irq_en_d;
  end

  always_comb begin
    status_word                     = '0;
    status_word[N_ERR-1:0]          = prim;
    status_word[HALF_BITS +: N_ERR] = sec;
    log_word                        = '0;
    log_word[N_ERR-1:0]             = log_en_q;
    irq                             = |(status_word & irq_en_q);
    unique case (sel)
      RA_STATUS: rdata = status_word;
      RA_LOG_EN: rdata = log_word;
      RA_IRQ_EN: rdata = irq_en_q;
      RA_RX_HI:  rdata = rx_hdr_q[HDR_BITS-1:WORD_BITS];
      RA_RX_LO:  rdata = rx_hdr_q[WORD_BITS-1:0];
      RA_TX_HI:  rdata = tx_hdr_q[HDR_BITS-1:WORD_BITS];
      RA_TX_LO:  rdata = tx_hdr_q[WORD_BITS-1:0];
      default:   rdata = '0;
    endcase
  end

  assign log_en = log_en_q;

  // R5: interrupt falls when no flags are set
  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((prim == '0) && (sec == '0)) |-> !irq);

endmodule

// File: rtl/err_log_unit.sv
module err_log_unit
  import err_log_pkg::*;
#(
  parameter int               N_ERR          = 32,
  parameter logic [N_ERR-1:0] PRIM_ONLY_MASK = 32'h0000_0800,
  parameter logic [N_ERR-1:0] HDR_LOG_MASK   = 32'h0000_FFFF,
  parameter int unsigned      FMT_POS        = 125
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ERR-1:0]     err_evt,
  input  logic [HDR_BITS-1:0]  rx_hdr,
  input  logic [HDR_BITS-1:0]  tx_hdr,
  input  logic                 reg_wr_en,
  input  logic [ADDR_BITS-1:0] reg_addr,
  input  logic [WORD_BITS-1:0] reg_wdata,
  output logic [WORD_BITS-1:0] reg_rdata,
  output logic                 irq_o
);

  localparam int N_HDR = 2;

  logic [N_ERR-1:0]                log_en;
  logic [N_ERR-1:0]                clr_prim;
  logic [N_ERR-1:0]                clr_sec;
  logic [N_ERR-1:0]                prim_q;
  logic [N_ERR-1:0]                sec_q;
  logic                            cap_fire;
  logic [N_HDR-1:0][HDR_BITS-1:0]  hdr_in_a;
  logic [N_HDR-1:0][HDR_BITS-1:0]  hdr_q_a;

  assign hdr_in_a[0] = rx_hdr;
  assign hdr_in_a[1] = tx_hdr;

  err_status_core #(
    .N_ERR(N_ERR), .PRIM_ONLY_MASK(PRIM_ONLY_MASK), .HDR_LOG_MASK(HDR_LOG_MASK)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .log_en(log_en),
    .clr_prim(clr_prim), .clr_sec(clr_sec),
    .prim_q(prim_q), .sec_q(sec_q), .cap_fire(cap_fire)
  );

  for (genvar g = 0; g < N_HDR; g++) begin : g_hdr
    err_hdr_capture #(.FMT_POS(FMT_POS)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(cap_fire),
      .hdr_in(hdr_in_a[g]), .hdr_q(hdr_q_a[g])
    );
  end

  err_reg_if #(.N_ERR(N_ERR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .prim(prim_q), .sec(sec_q),
    .rx_hdr_q(hdr_q_a[0]), .tx_hdr_q(hdr_q_a[1]),
    .log_en(log_en), .clr_prim(clr_prim), .clr_sec(clr_sec),
    .rdata(reg_rdata), .irq(irq_o)
  );

  // R10: both header snapshots change only together
  a_r10_hdr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hdr_q_a[1]) |-> $past(cap_fire));

endmodule

// File: tb/test_err_log_unit.sv
module test_err_log_unit;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  err_evt;
  logic [127:0] rx_hdr, tx_hdr;
  logic         reg_wr_en;
  logic [2:0]   reg_addr;
  logic [63:0]  reg_wdata;
  logic [63:0]  reg_rdata;
  logic         irq_o;

  always #10 clk = ~clk;

  err_log_unit i_err_log_unit (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .rx_hdr(rx_hdr), .tx_hdr(tx_hdr),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  localparam logic [31:0] PO_MASK  = 32'h0000_0800;
  localparam logic [31:0] HL_MASK  = 32'h0000_FFFF;

  typedef struct {
    logic [3:0]  sel;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0]  m_prim, m_sec, m_log;
  logic [63:0]  m_irqen;
  logic [127:0] m_rx, m_tx;

  function automatic logic [127:0] m_trim(input logic [127:0] h);
    logic [127:0] r;
    r = h;
    if (!h[125]) r[31:0] = '0;
    return r;
  endfunction

  function automatic logic [63:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_sec, m_prim};
      3'd1: return {32'h0, m_log};
      3'd2: return m_irqen;
      3'd3: return m_rx[127:64];
      3'd4: return m_rx[63:0];
      3'd5: return m_tx[127:64];
      3'd6: return m_tx[63:0];
      default: return 64'h0;
    endcase
  endfunction

  task automatic cyc(input logic [31:0] evt, input logic [127:0] rx, input logic [127:0] tx,
                     input logic wr, input logic [2:0] a, input logic [63:0] wd);
    logic [31:0] ev, cp, cs, eff, ps, ss;
    logic cap;
    @(negedge clk);
    err_evt = evt; rx_hdr = rx; tx_hdr = tx;
    reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    ev  = evt & m_log;
    cp  = (wr && a == 3'd0) ? wd[31:0]  : 32'h0;
    cs  = (wr && a == 3'd0) ? wd[63:32] : 32'h0;
    eff = m_prim & ~cp;
    ps  = ev & ~eff;
    ss  = ev & eff & ~PO_MASK;
    cap = (|(ps & HL_MASK)) && !(|(eff & HL_MASK));
    m_prim = eff | ps;
    m_sec  = (m_sec & ~cs) | ss;
    if (cap) begin m_rx = m_trim(rx); m_tx = m_trim(tx); end
    if (wr && a == 3'd1) m_log = wd[31:0];
    if (wr && a == 3'd2) m_irqen = wd;
  endtask

  task automatic pulse(input logic [31:0] evt, input logic [127:0] rx, input logic [127:0] tx);
    cyc(evt, rx, tx, 1'b0, 3'd0, 64'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    cyc(32'h0, '1, '1, 1'b1, a, d);
  endtask

  task automatic expect_reg(input logic [2:0] a, input string tag);
    item_t it;
    @(negedge clk);
    err_evt = '0; reg_wr_en = 1'b0; reg_addr = a; reg_wdata = '0;
    it.sel = {1'b0, a}; it.exp = m_read(a); it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic expect_irq(input string tag);
    item_t it;
    @(negedge clk);
    err_evt = '0; reg_wr_en = 1'b0;
    it.sel = 4'd8; it.exp = {63'h0, |({m_sec, m_prim} & m_irqen)}; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic expect_all(input string tag);
    for (int a = 0; a < 8; a++) expect_reg(3'(a), tag);
  endtask

  // monitor: pops and compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = exp_q.pop_front();
        act = (it.sel == 4'd8) ? {63'h0, irq_o} : reg_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [127:0] H4A = 128'h2A01_0004_1111_2222_3333_4444_5555_6666;
  localparam logic [127:0] T4A = 128'h2B02_0004_7777_8888_9999_AAAA_BBBB_CCCC;
  localparam logic [127:0] H4B = 128'h3C00_0001_0101_0202_0303_0404_0505_0606;
  localparam logic [127:0] H3A = 128'h0A01_0003_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF;
  localparam logic [127:0] T3A = 128'h0B05_0003_1234_5678_9ABC_DEF0_1357_2468;

  initial begin
    m_prim = '0; m_sec = '0; m_log = '0; m_irqen = '0; m_rx = '0; m_tx = '0;
    err_evt = '0; rx_hdr = '0; tx_hdr = '0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    expect_all("R1 reset");
    expect_irq("R1 reset irq");

    pulse(32'h0000_0008, H4A, T4A);
    expect_reg(3'd0, "R2 event with all enables off");

    wr(3'd1, 64'hFFFF_FFFF_0FFF_FFFF);
    expect_reg(3'd1, "R12 log enable upper half");
    pulse(32'h2000_0000, H4A, T4A);
    expect_reg(3'd0, "R2 disabled line 29");

    pulse(32'h0000_0008, H4A, T4A);
    expect_reg(3'd0, "R3 first occurrence");
    expect_reg(3'd3, "R8 R9 rx high");
    expect_reg(3'd4, "R9 four-doubleword low word kept");
    expect_reg(3'd5, "R10 tx high");
    expect_reg(3'd6, "R10 tx low");

    pulse(32'h0000_0008, H4B, H3A);
    expect_reg(3'd0, "R3 repeat sets secondary");
    expect_reg(3'd3, "R8 header held");
    expect_reg(3'd6, "R8 tx held");

    pulse(32'h0000_0800, H4B, H4B);
    pulse(32'h0000_0800, H4B, H4B);
    expect_reg(3'd0, "R4 primary-only bit 11");

    pulse(32'h0010_00A8, H4B, H4B);
    expect_reg(3'd0, "R11 parallel burst");

    expect_irq("R5 irq disabled");
    wr(3'd2, 64'h0000_0008_0000_0000);
    expect_irq("R5 irq on secondary 3");
    expect_reg(3'd2, "R5 irq enable readback");
    wr(3'd0, 64'h0000_0008_0000_0000);
    expect_irq("R5 irq after secondary cleared");
    expect_reg(3'd0, "R6 secondary clear");

    wr(3'd3, 64'hDEAD_BEEF_DEAD_BEEF);
    wr(3'd6, 64'hDEAD_BEEF_DEAD_BEEF);
    expect_reg(3'd3, "R6 header write ignored");
    expect_reg(3'd6, "R6 tx header write ignored");

    wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_reg(3'd0, "R6 clear all");

    pulse(32'h0010_0000, H3A, T3A);
    expect_reg(3'd3, "R8 non-logging error no capture");

    pulse(32'h0000_0200, H3A, T3A);
    expect_reg(3'd3, "R8 recapture after clear");
    expect_reg(3'd4, "R9 short header low word zero");
    expect_reg(3'd6, "R10 short tx low word zero");

    pulse(32'h0000_0004, H4A, T4A);
    cyc(32'h0000_0004, H4A, T4A, 1'b1, 3'd0, 64'h0000_0000_0000_0004);
    expect_reg(3'd0, "R7 event wins over clear");

    wr(3'd2, 64'h0000_0000_0000_0004);
    expect_irq("R5 irq on primary 2");
    expect_reg(3'd7, "R12 spare address");

    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule